// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Index Generator

This block removes the three nested loops of an in-place radix-2 decimation-in-time FFT from the instruction stream. It runs all of them in one state machine. After a start strobe it walks every stage, every group inside a stage and every butterfly inside a group. For each butterfly it presents the two data positions and the twiddle-table position. An execution unit can then issue one and the same 3-input, 2-output butterfly, `t = X[hi]*W[k]; X[hi] = X[lo] - t; X[lo] = X[lo] + t`, once per presented triplet. Both results go back to the positions they were read from.

The transform length is given as its base-2 logarithm. The data is assumed to be loaded in bit-reversed order already; for eight points, position 1 holds sample 4 and position 6 holds sample 3. The generator does not do that reordering. It also does not do the arithmetic and does not hold the twiddle values. Triplets leave through a valid/ready handshake, and a done flag marks the final one.

Top module: `fft_bfly_agen`

## Requirements
- R1: After reset `out_valid` and `done` are low and stay low until a start is accepted.
- R2: When idle, `start` with `log2_len` in 1..MAX_LOG2 (default 6) is accepted. The first triplet (lo=0, hi=1, twid=0) is valid on the cycle after the accepting edge.
- R3: Triplets follow stage size 2, 4, ... n. Within a stage, group bases run 0, size, 2*size, ... Within a group, lo runs from base to base+size/2-1. In every triplet, hi = lo + size/2.
- R4: `twid` is 0 at the first butterfly of every group and grows by n/size with each following butterfly of that group.
- R5: Exactly (n/2)*log2(n) triplets are delivered per run. After the last one `out_valid` is low.
- R6: While `out_valid` is high and `out_ready` is low, the triplet and `done` hold unchanged.
- R7: `done` is high only together with the valid final triplet of the last stage. The cycle after that triplet is taken, `out_valid` is low.
- R8: `start` while a run is in progress has no effect on the sequence.
- R9: `start` with `log2_len` equal to 0 or above MAX_LOG2 is ignored, so `out_valid` stays low.
- R10: `log2_len` is only sampled at the accepting edge. Changing it during a run does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform schedule |
| log2_len | input | $clog2(MAX_LOG2+1) | Base-2 logarithm of the transform length |
| out_ready | input | 1 | Consumer takes the current triplet |
| out_valid | output | 1 | Triplet is present |
| idx_lo | output | MAX_LOG2 | Lower data position (j) |
| idx_hi | output | MAX_LOG2 | Upper data position (j + size/2) |
| twid | output | MAX_LOG2 | Twiddle-table position (k) |
| done | output | 1 | Current triplet is the final one of the run |

## Verification
The bench builds the block with the default MAX_LOG2 of 6. This keeps the largest schedule at 192 triplets, so every legal length from 2 to 64 points can be walked in full. Each length runs twice: once with the consumer always ready and once with a repeating stall pattern. The expected lo, hi, twid and done values come from the bench's own triple loop, which makes every stage, group and butterfly boundary a checked point. Start pulses and length changes are injected during runs, and both out-of-range length codes are tried.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

endpackage

// File: rtl/fft_agen_len_chk.sv
module fft_agen_len_chk #(
    parameter int MAX_LOG2 = 6,
    localparam int LW = $clog2(MAX_LOG2 + 1)
) (
    input  logic          start,
    input  logic          busy,
    input  logic [LW-1:0] log2_len,
    output logic          launch
);

    logic len_ok;

    // A length code is legal from 1 up to the built maximum (R9)
    always_comb begin
        len_ok = (log2_len != '0) && (int'(log2_len) <= MAX_LOG2);
        launch = start && !busy && len_ok;   // R8: ignored while running
    end

endmodule

// File: rtl/fft_agen_walk.sv
module fft_agen_walk
    import fft_agen_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    localparam int LW = $clog2(MAX_LOG2 + 1),
    localparam int IW = MAX_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [LW-1:0] log2_len,
    input  logic          out_ready,
    output logic          busy,
    output logic          out_valid,
    output logic [IW-1:0] idx_lo,
    output logic [IW-1:0] idx_hi,
    output logic [IW-1:0] twid,
    output logic          done
);

    typedef struct packed {
        walk_state_e   st;
        logic [LW-1:0] lg;     // captured length code (R10)
        logic [LW-1:0] stg;    // stage number, half size = 1 << stg
        logic [IW-1:0] base;   // group start
        logic [IW-1:0] off;    // butterfly offset inside group
        logic [IW-1:0] k;      // twiddle position
    } walk_t;

    walk_t w_d, w_q;

    logic [IW:0]   half_w, size_w, len_w, grp_end;
    logic [IW-1:0] step_w;
    logic [LW-1:0] shift_w;
    logic          last_bf, last_grp, last_stg, fire;

    always_comb begin
        half_w   = (IW+1)'(1) << w_q.stg;
        size_w   = half_w << 1;
        len_w    = (IW+1)'(1) << w_q.lg;
        shift_w  = w_q.lg - w_q.stg - LW'(1);
        step_w   = IW'(1) << shift_w;
        grp_end  = {1'b0, w_q.base} + size_w;
        last_bf  = ({1'b0, w_q.off} == half_w - (IW+1)'(1));
        last_grp = (grp_end == len_w);
        last_stg = (w_q.stg == w_q.lg - LW'(1));

        out_valid = (w_q.st == WALK_RUN);
        busy      = out_valid;
        idx_lo    = w_q.base + w_q.off;
        idx_hi    = idx_lo + half_w[IW-1:0];
        twid      = w_q.k;
        done      = out_valid && last_bf && last_grp && last_stg;
        fire      = out_valid && out_ready;

        w_d = w_q;
        if (w_q.st == WALK_IDLE) begin
            if (launch) begin
                w_d.st   = WALK_RUN;
                w_d.lg   = log2_len;
                w_d.stg  = '0;
                w_d.base = '0;
                w_d.off  = '0;
                w_d.k    = '0;
            end
        end else if (fire) begin
            if (!last_bf) begin
                w_d.off = w_q.off + IW'(1);
                w_d.k   = w_q.k + step_w;          // R4
            end else begin
                w_d.off = '0;
                w_d.k   = '0;                      // R4: new group
                if (!last_grp) begin
                    w_d.base = grp_end[IW-1:0];
                end else begin
                    w_d.base = '0;
                    if (last_stg) begin
                        w_d.st = WALK_IDLE;        // R7
                    end else begin
                        w_d.stg = w_q.stg + LW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: WALK_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    // R3: the pair differs in exactly one bit, hi above lo
    a_r3_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx_hi > idx_lo) && $onehot(idx_hi ^ idx_lo));

    // R4: twiddle position stays below n/2
    a_r4_twid_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, twid} < (len_w >> 1)));

    // R6: stalled triplet holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(idx_lo)
            && $stable(idx_hi) && $stable(twid) && $stable(done));

    // R7: done only with a triplet
    a_r7_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);

    // R7: the run ends once the final triplet is taken
    a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && done) |=> !out_valid);

    // R8: a run continues until its final triplet is taken
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && done)) |=> out_valid);

endmodule

// File: rtl/fft_bfly_agen.sv
module fft_bfly_agen #(
    parameter int MAX_LOG2 = 6,
    localparam int LW = $clog2(MAX_LOG2 + 1),
    localparam int IW = MAX_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] log2_len,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [IW-1:0] idx_lo,
    output logic [IW-1:0] idx_hi,
    output logic [IW-1:0] twid,
    output logic          done
);

    logic launch;
    logic busy;

    fft_agen_len_chk #(.MAX_LOG2(MAX_LOG2)) u_len (
        .start    (start),
        .busy     (busy),
        .log2_len (log2_len),
        .launch   (launch)
    );

    fft_agen_walk #(.MAX_LOG2(MAX_LOG2)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .log2_len  (log2_len),
        .out_ready (out_ready),
        .busy      (busy),
        .out_valid (out_valid),
        .idx_lo    (idx_lo),
        .idx_hi    (idx_hi),
        .twid      (twid),
        .done      (done)
    );

    // R1: nothing presented straight out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && !done);

endmodule

// File: tb/fft_bfly_agen_test.sv
`timescale 1ns/1ps
module fft_bfly_agen_test;

    localparam int MAX_LOG2 = 6;
    localparam int LW = $clog2(MAX_LOG2 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] log2_len = '0;
    logic          out_ready = 1'b0;
    logic          out_valid, done;
    logic [MAX_LOG2-1:0] idx_lo, idx_hi, twid;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int wd = 0;

    always #4 clk = ~clk;

    fft_bfly_agen #(.MAX_LOG2(MAX_LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .log2_len(log2_len),
        .out_ready(out_ready), .out_valid(out_valid), .idx_lo(idx_lo),
        .idx_hi(idx_hi), .twid(twid), .done(done)
    );

    task automatic chk(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            nfail++;
            $display("FAIL R2 watchdog actual=%0d expected=<150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic run_len(input int L, input int mode);
        int n = 1 << L;
        int nfire = 0;
        @(negedge clk);
        log2_len = LW'(L);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        log2_len = LW'(7 - L);   // R10: change mid-run
        for (int s = 0; s < L; s++) begin
            for (int i = 0; i < n; i += (2 << s)) begin
                for (int jo = 0; jo < (1 << s); jo++) begin
                    int ej = i + jo;
                    int eh = ej + (1 << s);
                    int ek = jo * (n >> (s + 1));
                    int el = ((s == L - 1) && (i + (2 << s) == n) && (jo == (1 << s) - 1)) ? 1 : 0;
                    bit fired = 1'b0;
                    while (!fired) begin
                        bit rdy;
                        chk(int'(out_valid), 1, "R2 valid");
                        chk(int'(idx_lo), ej, "R3 lo");
                        chk(int'(idx_hi), eh, "R3 hi");
                        chk(int'(twid), ek, "R4 twid");
                        chk(int'(done), el, "R7 done");
                        rdy = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);  // R6 stalls
                        out_ready = rdy;
                        start = ((cyc % 5) == 0);                      // R8
                        @(negedge clk);
                        cyc++;
                        fired = rdy;
                    end
                    nfire++;
                end
            end
        end
        out_ready = 1'b0;
        start = 1'b0;
        chk(nfire, (n / 2) * L, "R5 count");
        chk(int'(out_valid), 0, "R5 valid low after last");
        @(negedge clk);
        chk(int'(out_valid), 0, "R7 stays idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(out_valid), 0, "R1 valid");
        chk(int'(done), 0, "R1 done");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(out_valid), 0, "R1 valid after release");

        // R9: illegal length codes
        for (int b = 0; b < 2; b++) begin
            log2_len = (b == 0) ? LW'(0) : LW'(7);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 3; c++) begin
                chk(int'(out_valid), 0, "R9 ignored");
                @(negedge clk);
            end
        end

        for (int mode = 0; mode < 2; mode++)
            for (int L = 1; L <= MAX_LOG2; L++)
                run_len(L, mode);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule